// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the beam timing for a raster display. A horizontal counter steps once for every pixel-clock enable and a vertical counter steps once per line. From the two positions the block derives horizontal sync, vertical sync, composite sync and a blank signal. It also gives out the beam position, the interlace field and a one-clock start-of-frame pulse. Every edge of the raster is a software value written through a small register port. The line length, the frame length, both sync windows, both blank windows and a mid-line point are all set this way. The mid-line point shifts the vertical sync edges of the odd field when interlace is on.

Software writes go into a shadow copy. The whole shadow copy, together with the interlace control, moves into the active timing only at the end of a frame. Because of this, a frame never runs with a mix of old and new timing. Each of the three sync pins has its own polarity input, and that input acts at once. Totals are "last value" registers: a total of N gives N+1 counts. The reset state is a 1x1 raster, so the first pixel enable after any programming already loads the new timing.

Top module: `raster_sync_gen`

## Requirements
- R1: After synchronous reset, hpos, vpos, field and sof are 0. All timing registers are 0, so no sync or blank window is open. Each sync pin shows its inactive level.
- R2: hpos advances by one on each clock with pix_en high. In the step after it equals the active horizontal total, it returns to 0. A line is therefore total+1 counts long.
- R3: vpos advances by one at each line end, which is the step where hpos wraps. After it equals the active vertical total, it returns to 0 at the following line end.
- R4: With pix_en low, hpos, vpos and field hold their values.
- R5: The raw horizontal sync is active while hpos lies in [hsync start, hsync stop). When start is greater than stop, the window wraps past the line end. An equal start and stop gives no sync.
- R6: blank is high while hpos lies in the horizontal blank window or vpos lies in the vertical blank window. Both windows are half-open and may wrap, and they are set apart from the sync registers.
- R7: The raw vertical sync starts at position (vsync start line, E) and ends at position (vsync stop line, E). Positions are ordered by line first, then by hpos. E is the mid-line register value while interlace is in effect and field is 1; otherwise E is 0.
- R8: At the end of a frame that ran with interlace in effect, field toggles. At the end of any other frame, field is cleared.
- R9: Each sync pin equals its raw value when its polarity input is 1 and the inverse when the polarity input is 0.
- R10: The raw composite sync is the XOR of raw hsync and raw vsync. cs_pol is applied to it afterwards.
- R11: wr_en writes wr_data into the shadow register chosen by wr_sel. The encoding is 0 htotal, 1 hsync start, 2 hsync stop, 3 hblank start, 4 hblank stop, 5 mid-line, 6 vtotal, 7 vsync start, 8 vsync stop, 9 vblank start, 10 vblank stop. Codes 11 to 15 are ignored. The shadow copy, including a write made in that same clock, becomes active only at the clock where the frame wraps. lace_en is sampled at that same clock.
- R12: sof is high for exactly the one clock after the frame wraps, when hpos and vpos are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; advances the beam |
| wr_en | input | 1 | Timing register write strobe |
| wr_sel | input | 4 | Timing register select |
| wr_data | input | 12 | Timing register write value |
| lace_en | input | 1 | Interlace request, sampled at frame wrap |
| hs_pol | input | 1 | hsync polarity, 1 = active high |
| vs_pol | input | 1 | vsync polarity, 1 = active high |
| cs_pol | input | 1 | csync polarity, 1 = active high |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| csync | output | 1 | Composite sync pin |
| blank | output | 1 | Blank, active high |
| hpos | output | 12 | Horizontal beam position |
| vpos | output | 12 | Vertical beam position |
| field | output | 1 | Interlace field |
| sof | output | 1 | Start-of-frame pulse |

## Verification
The hardest case to reach is the odd-field vertical sync. It only exists after a frame has run with interlace in effect, and only then do its edges fall at the mid-line point instead of the line start. To get there, the stimulus sets lace_en and lets one frame commit it. A second frame then toggles the field. The run continues for several frames so that both fields are compared cycle by cycle against a reference model. The second hard case is a timing write landing mid-frame. A new line total is written on line 1, and the stimulus confirms that the running frame keeps its old line length while the next frame takes the new one.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    parameter int CNT_W = 12;
    parameter int SEL_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_HTOT   = 4'd0,
        SEL_HS_BEG = 4'd1,
        SEL_HS_END = 4'd2,
        SEL_HB_BEG = 4'd3,
        SEL_HB_END = 4'd4,
        SEL_HMID   = 4'd5,
        SEL_VTOT   = 4'd6,
        SEL_VS_BEG = 4'd7,
        SEL_VS_END = 4'd8,
        SEL_VB_BEG = 4'd9,
        SEL_VB_END = 4'd10
    } reg_sel_e;

    typedef struct packed {
        cnt_t htot;
        cnt_t hs_beg;
        cnt_t hs_end;
        cnt_t hb_beg;
        cnt_t hb_end;
        cnt_t hmid;
        cnt_t vtot;
        cnt_t vs_beg;
        cnt_t vs_end;
        cnt_t vb_beg;
        cnt_t vb_end;
        logic lace;
    } timing_t;

    // half-open window that may wrap around the counter end
    function automatic logic in_span(cnt_t pos, cnt_t beg, cnt_t fin);
        if (beg <= fin)
            return (pos >= beg) && (pos < fin);
        else
            return (pos >= beg) || (pos < fin);
    endfunction

    // beam position (v,h) is at or beyond point (pv,ph), ordered line first
    function automatic logic at_or_after(cnt_t v, cnt_t h, cnt_t pv, cnt_t ph);
        return (v > pv) || ((v == pv) && (h >= ph));
    endfunction

    function automatic timing_t apply_write(timing_t t, reg_sel_e sel, cnt_t d);
        timing_t r;
        r = t;
        case (sel)
            SEL_HTOT:   r.htot   = d;
            SEL_HS_BEG: r.hs_beg = d;
            SEL_HS_END: r.hs_end = d;
            SEL_HB_BEG: r.hb_beg = d;
            SEL_HB_END: r.hb_end = d;
            SEL_HMID:   r.hmid   = d;
            SEL_VTOT:   r.vtot   = d;
            SEL_VS_BEG: r.vs_beg = d;
            SEL_VS_END: r.vs_end = d;
            SEL_VB_BEG: r.vb_beg = d;
            SEL_VB_END: r.vb_end = d;
            default:    r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rsg_regs.sv
module rsg_regs
    import rsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  cnt_t             wr_data,
    input  logic             lace_in,
    input  logic             commit,
    output timing_t          active
);

    timing_t shadow;
    timing_t shadow_nxt;
    timing_t load_val;

    always_comb begin
        shadow_nxt = wr_en ? apply_write(shadow, reg_sel_e'(wr_sel), wr_data) : shadow;
        load_val      = shadow_nxt;
        load_val.lace = lace_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            shadow <= shadow_nxt;
            if (commit)
                active <= load_val;
        end
    end

    // R11
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active));

endmodule

// File: rtl/rsg_beam.sv
module rsg_beam
    import rsg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pix_en,
    input  timing_t act,
    output cnt_t    hpos,
    output cnt_t    vpos,
    output logic    field,
    output logic    wrap
);

    logic line_end;

    always_comb begin
        line_end = pix_en && (hpos == act.htot);
        wrap     = line_end && (vpos == act.vtot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos  <= '0;
            vpos  <= '0;
            field <= 1'b0;
        end else begin
            if (pix_en)
                hpos <= line_end ? '0 : hpos + 1'b1;
            if (line_end)
                vpos <= wrap ? '0 : vpos + 1'b1;
            if (wrap)
                field <= act.lace ? ~field : 1'b0;
        end
    end

    // R2
    hpos_range_chk: assert property (@(posedge clk) disable iff (rst)
        hpos <= act.htot);

    // R4
    beam_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(hpos) && $stable(vpos) && $stable(field));

    // R3
    vpos_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hpos == act.htot && vpos != act.vtot) |=> vpos == $past(vpos) + 1'b1);

endmodule

// File: rtl/rsg_decode.sv
module rsg_decode
    import rsg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  timing_t act,
    input  cnt_t    hpos,
    input  cnt_t    vpos,
    input  logic    field,
    input  logic    hs_pol,
    input  logic    vs_pol,
    input  logic    cs_pol,
    output logic    hsync,
    output logic    vsync,
    output logic    csync,
    output logic    blank
);

    logic h_raw;
    logic v_raw;
    logic c_raw;
    cnt_t v_edge;

    always_comb begin
        v_edge = (act.lace && field) ? act.hmid : '0;
        h_raw  = in_span(hpos, act.hs_beg, act.hs_end);
        v_raw  = at_or_after(vpos, hpos, act.vs_beg, v_edge) &&
                 !at_or_after(vpos, hpos, act.vs_end, v_edge);
        c_raw  = h_raw ^ v_raw;
        blank  = in_span(hpos, act.hb_beg, act.hb_end) ||
                 in_span(vpos, act.vb_beg, act.vb_end);
        hsync  = hs_pol ? h_raw : ~h_raw;
        vsync  = vs_pol ? v_raw : ~v_raw;
        csync  = cs_pol ? c_raw : ~c_raw;
    end

    // R10
    csync_mix_chk: assert property (@(posedge clk) disable iff (rst)
        (csync ^ ~cs_pol) == ((hsync ^ ~hs_pol) ^ (vsync ^ ~vs_pol)));

    // R7
    vsync_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (vsync ^ ~vs_pol) |-> (vpos >= act.vs_beg) && (vpos <= act.vs_end));

    // R6
    blank_start_chk: assert property (@(posedge clk) disable iff (rst)
        (hpos == act.hb_beg && act.hb_beg != act.hb_end) |-> blank);

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import rsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             lace_en,
    input  logic             hs_pol,
    input  logic             vs_pol,
    input  logic             cs_pol,
    output logic             hsync,
    output logic             vsync,
    output logic             csync,
    output logic             blank,
    output logic [CNT_W-1:0] hpos,
    output logic [CNT_W-1:0] vpos,
    output logic             field,
    output logic             sof
);

    timing_t act;
    logic    wrap;

    rsg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .lace_in (lace_en),
        .commit  (wrap),
        .active  (act)
    );

    rsg_beam u_beam (
        .clk    (clk),
        .rst    (rst),
        .pix_en (pix_en),
        .act    (act),
        .hpos   (hpos),
        .vpos   (vpos),
        .field  (field),
        .wrap   (wrap)
    );

    rsg_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .hpos   (hpos),
        .vpos   (vpos),
        .field  (field),
        .hs_pol (hs_pol),
        .vs_pol (vs_pol),
        .cs_pol (cs_pol),
        .hsync  (hsync),
        .vsync  (vsync),
        .csync  (csync),
        .blank  (blank)
    );

    always_ff @(posedge clk) begin
        if (rst) sof <= 1'b0;
        else     sof <= wrap;
    end

    // R12
    sof_origin_chk: assert property (@(posedge clk) disable iff (rst)
        sof |-> (hpos == '0) && (vpos == '0));

endmodule

// File: tb/raster_sync_gen_tb.sv
`timescale 1ns/1ps
module raster_sync_gen_tb;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pix_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic         lace_en = 1'b0;
    logic         hs_pol = 1'b1;
    logic         vs_pol = 1'b0;
    logic         cs_pol = 1'b1;
    logic         hsync, vsync, csync, blank, field, sof;
    logic [W-1:0] hpos, vpos;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    raster_sync_gen u_dut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .lace_en(lace_en), .hs_pol(hs_pol), .vs_pol(vs_pol),
        .cs_pol(cs_pol), .hsync(hsync), .vsync(vsync), .csync(csync),
        .blank(blank), .hpos(hpos), .vpos(vpos), .field(field), .sof(sof)
    );

    typedef struct {
        int h; int v; int f; int hs; int vs; int cs; int bl; int sf;
    } exp_t;
    exp_t exp_q[$];

    // reference model state
    int sh[11];
    int ac[11];
    int m_lace = 0;
    int m_h = 0, m_v = 0, m_f = 0, m_sof = 0;

    task automatic check(input string tag, input int got, input int want);
        n_checks++;
        if (got != want) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, want, $time);
        end
    endtask

    function automatic int window(int p, int b, int e);
        if (b <= e) return (p >= b && p < e) ? 1 : 0;
        return (p >= b || p < e) ? 1 : 0;
    endfunction

    function automatic int reached(int v, int h, int pv, int ph);
        return (v > pv || (v == pv && h >= ph)) ? 1 : 0;
    endfunction

    function automatic exp_t expect_now();
        exp_t e;
        int hr, vr, ve;
        hr = window(m_h, ac[1], ac[2]);
        ve = (m_lace != 0 && m_f != 0) ? ac[5] : 0;
        vr = reached(m_v, m_h, ac[7], ve) & (1 - reached(m_v, m_h, ac[8], ve));
        e.h  = m_h;
        e.v  = m_v;
        e.f  = m_f;
        e.hs = hs_pol ? hr : 1 - hr;
        e.vs = vs_pol ? vr : 1 - vr;
        e.cs = cs_pol ? (hr ^ vr) : 1 - (hr ^ vr);
        e.bl = window(m_h, ac[3], ac[4]) | window(m_v, ac[9], ac[10]);
        e.sf = m_sof;
        return e;
    endfunction

    // driver: drive one clock of stimulus, advance model, queue the expectation
    task automatic step(input int pix, input int we, input int sel, input int data);
        int le, fe;
        pix_en  = (pix != 0);
        wr_en   = (we != 0);
        wr_sel  = sel[3:0];
        wr_data = data[W-1:0];
        @(posedge clk);
        le = (pix != 0 && m_h == ac[0]) ? 1 : 0;
        fe = (le != 0 && m_v == ac[6]) ? 1 : 0;
        if (we != 0 && sel <= 10) sh[sel] = data;
        if (pix != 0) m_h = (le != 0) ? 0 : m_h + 1;
        if (le != 0) m_v = (fe != 0) ? 0 : m_v + 1;
        if (fe != 0) begin
            m_f = (m_lace != 0) ? 1 - m_f : 0;
            ac = sh;
            m_lace = lace_en ? 1 : 0;
        end
        m_sof = fe;
        exp_q.push_back(expect_now());
        @(negedge clk);
    endtask

    // monitor: compare queued expectations away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check("R2 hpos", int'(hpos), e.h);
                check("R3 vpos", int'(vpos), e.v);
                check("R8 field", int'(field), e.f);
                check("R5 R9 hsync", int'(hsync), e.hs);
                check("R7 R9 vsync", int'(vsync), e.vs);
                check("R10 csync", int'(csync), e.cs);
                check("R6 blank", int'(blank), e.bl);
                check("R12 sof", int'(sof), e.sf);
            end
        end
    end

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        int max_h;
        for (int i = 0; i < 11; i++) begin sh[i] = 0; ac[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 hpos", int'(hpos), 0);
        check("R1 vpos", int'(vpos), 0);
        check("R1 field", int'(field), 0);
        check("R1 sof", int'(sof), 0);
        check("R1 hsync", int'(hsync), 0);
        check("R1 vsync", int'(vsync), 1);
        check("R1 csync", int'(csync), 0);
        check("R1 blank", int'(blank), 0);
        @(negedge clk);

        // R11 program a 10x6 raster while the beam is parked
        step(0, 1, 0, 9);
        step(0, 1, 1, 6);
        step(0, 1, 2, 8);
        step(0, 1, 3, 8);
        step(0, 1, 4, 1);
        step(0, 1, 5, 4);
        step(0, 1, 6, 5);
        step(0, 1, 7, 3);
        step(0, 1, 8, 4);
        step(0, 1, 9, 5);
        step(0, 1, 10, 1);
        step(0, 1, 13, 2);   // ignored code
        step(1, 0, 0, 0);    // 1x1 frame wraps, shadow committed
        check("R11 commit sof", int'(sof), 1);

        // progressive frames
        for (int i = 0; i < 180; i++) step(1, 0, 0, 0);

        // R4 stalls
        for (int i = 0; i < 45; i++) begin
            if (i % 3 == 0) begin
                logic [W-1:0] hold_h;
                hold_h = hpos;
                step(0, 0, 0, 0);
                check("R4 hold", int'(hpos), int'(hold_h));
            end else begin
                step(1, 0, 0, 0);
            end
        end

        // R9 other polarities
        hs_pol = 1'b0; vs_pol = 1'b1; cs_pol = 1'b0;
        for (int i = 0; i < 70; i++) step(1, 0, 0, 0);

        // R8 interlace, sampled at the next wrap
        lace_en = 1'b1;
        for (int i = 0; i < 300; i++) step(1, 0, 0, 0);
        lace_en = 1'b0;

        // R11 mid-frame write: align to frame start, then move to line 1
        for (int i = 0; i < 200 && sof == 1'b0; i++) step(1, 0, 0, 0);
        for (int i = 0; i < 20 && vpos != 1; i++) step(1, 0, 0, 0);
        step(1, 1, 0, 5);
        step(1, 1, 15, 3);
        max_h = 0;
        for (int i = 0; i < 200; i++) begin
            step(1, 0, 0, 0);
            if (int'(hpos) > max_h) max_h = int'(hpos);
            if (sof) break;
        end
        check("R11 old line length kept", max_h, 9);
        max_h = 0;
        for (int i = 0; i < 200; i++) begin
            step(1, 0, 0, 0);
            if (int'(hpos) > max_h) max_h = int'(hpos);
            if (sof) break;
        end
        check("R11 new line length", max_h, 5);
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0);

        @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule